// File: doc/BRIEF.md
# Pixel Hit Memory and Configuration Cell

This block is the digital part of one detector pixel. A discriminator reports a hit through an active-low level. Three active-low strobe windows each open one hit memory bit. While a bit's window is low and a hit is present, that bit is set, so the pixel can record up to three time slices on its own. A one-hot active-low memory select picks which bit is shown to the readout priority encoder through one active-high state output. The same select picks which bit a falling edge on the encoder's reset clears. An active-low global clear wipes every bit.

Two configuration latches, a mask and a pulse enable, are loaded from one shared data line. A load happens only when both the column strobe and the row strobe of the pixel are high, and a register select steers the data to one latch or the other. A shared test-pulse line is sent either into the digital hit path, where it acts like a front-end hit, or out as an analogue injection request. The pulse type input picks the route, and the pulse enable bit gates both routes.

The model is synchronous: every level is sampled on `clk`, and the encoder reset edge is found against a registered copy of that reset.

Top module: `pixel_hit_cell`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `state_out` is 0 for every select. The mask and pulse-enable bits are 0, so `apulse_req` is 0 even when `pulse`=1 and `pulse_type`=1.
- R2: A bit i becomes 1 one clock after a cycle in which `strobe_n[i]`=0 and the hit is present. The hit is present when `fe_hit_n`=0, or when a digital pulse is active. No other bit changes.
- R3: With every strobe high, a hit leaves all bits unchanged. A low strobe without a hit leaves its bit unchanged.
- R4: `state_out` is the OR of the bits whose `mem_sel_n` line is 0, masked as in R8. Bit i is selected by `mem_sel_n[i]`=0, and with no line low the output is 0. The output follows the select in the same cycle.
- R5: When `glob_clr_n`=0 at a clock edge, every bit is 0 after that edge.
- R6: A 1-to-0 transition of `enc_rst` between two consecutive clock samples clears, at the second edge, only the bits selected at that edge. A rising `enc_rst`, or `enc_rst` held at either level, clears nothing.
- R7: If a clear (R5 or R6) and a set (R2) reach the same bit in the same cycle, the bit ends up 0.
- R8: While the mask bit is 1, `state_out` is 0. The stored bits are kept and show again once the mask is cleared.
- R9: `cfg_data` is loaded at a clock edge only when `cfg_col`=1 and `cfg_row`=1 together. `cfg_reg`=0 loads the pulse-enable bit and `cfg_reg`=1 loads the mask bit. Otherwise both bits hold.
- R10: `apulse_req` = `pulse` AND `pulse_type` AND pulse-enable, combinationally. With `pulse_type`=1 the pulse never sets a hit bit.
- R11: With `pulse_type`=0, `pulse`=1 acts as a hit for R2 only while the pulse-enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset of all storage |
| fe_hit_n | input | 1 | Discriminator output, low on hit |
| strobe_n | input | 3 | Per-bit capture windows, active low |
| mem_sel_n | input | 3 | One-hot read/clear select, active low |
| glob_clr_n | input | 1 | Clears all hit bits, active low |
| enc_rst | input | 1 | Reset from encoder, acts on its falling edge |
| pulse_type | input | 1 | 0 = digital injection, 1 = analogue request |
| pulse | input | 1 | Shared test-pulse line |
| cfg_data | input | 1 | Configuration data line |
| cfg_col | input | 1 | Column select for configuration |
| cfg_row | input | 1 | Row select for configuration |
| cfg_reg | input | 1 | 0 = pulse enable, 1 = mask |
| state_out | output | 1 | Selected hit bit to encoder, active high |
| apulse_req | output | 1 | Analogue injection request |

## Verification
Each bit is captured alone and then read under all three selects, so a capture that lands in the wrong bit shows up as a 1 under the wrong select. Hits without strobes and strobes without hits are applied to separate the two capture conditions. The encoder reset is driven high, held and then lowered, so a design acting on the level or on the rising edge gives a different result from one acting on the falling edge. Several thousand random cycles mix configuration writes with partial row/column selects, pulses of both types, and colliding set and clear, and the output is compared each cycle against an arithmetic model.

// File: rtl/pixel_pkg.sv
package pixel_pkg;

    typedef enum logic {
        CFG_PULSE_EN = 1'b0,
        CFG_MASK     = 1'b1
    } cfg_target_e;

    typedef struct packed {
        logic mask;
        logic pulse_en;
    } cfg_t;

    // Per-bit set/clear request pair
    typedef struct packed {
        logic set;
        logic clr;
    } sr_req_t;

    // Next value of a set/reset bit, clear dominating
    function automatic logic sr_next(input logic cur, input sr_req_t req);
        if (req.clr)      return 1'b0;
        else if (req.set) return 1'b1;
        else              return cur;
    endfunction

endpackage

// File: rtl/pixel_cfg_latch.sv
module pixel_cfg_latch
    import pixel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_data,
    input  logic cfg_col,
    input  logic cfg_row,
    input  logic cfg_reg,
    output cfg_t cfg_q
);

    logic        wr_en;
    cfg_target_e target;

    assign wr_en  = cfg_col & cfg_row;
    assign target = cfg_target_e'(cfg_reg);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            if (target == CFG_MASK) cfg_q.mask     <= cfg_data;
            else                    cfg_q.pulse_en <= cfg_data;
        end
    end

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cfg_col && cfg_row) |=> $stable(cfg_q));

endmodule

// File: rtl/pixel_pulse_route.sv
module pixel_pulse_route (
    input  logic pulse,
    input  logic pulse_type,
    input  logic pulse_en,
    output logic dpulse,
    output logic apulse
);

    logic gated;

    assign gated  = pulse & pulse_en;
    assign dpulse = gated & ~pulse_type;
    assign apulse = gated &  pulse_type;

    // R10
    route_excl_chk: assert final (!(dpulse && apulse));

endmodule

// File: rtl/pixel_hit_store.sv
module pixel_hit_store
    import pixel_pkg::*;
#(
    parameter int NUM_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hit,
    input  logic [NUM_BITS-1:0] strobe_n,
    input  logic [NUM_BITS-1:0] mem_sel_n,
    input  logic                glob_clr_n,
    input  logic                enc_rst,
    output logic [NUM_BITS-1:0] bits_q
);

    logic                enc_q;
    logic                enc_fall;
    sr_req_t             req [NUM_BITS];

    always_ff @(posedge clk) begin
        if (rst) enc_q <= 1'b0;
        else     enc_q <= enc_rst;
    end

    assign enc_fall = enc_q & ~enc_rst;

    for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
        assign req[i].set = hit & ~strobe_n[i];
        assign req[i].clr = ~glob_clr_n | (enc_fall & ~mem_sel_n[i]);

        always_ff @(posedge clk) begin
            if (rst) bits_q[i] <= 1'b0;
            else     bits_q[i] <= sr_next(bits_q[i], req[i]);
        end

        // R7
        clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (!glob_clr_n || (enc_q && !enc_rst && !mem_sel_n[i])) |=> !bits_q[i]);

        // R2
        capture_chk: assert property (@(posedge clk) disable iff (rst)
            (hit && !strobe_n[i] && glob_clr_n && !(enc_q && !enc_rst)) |=> bits_q[i]);

        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (strobe_n[i] && glob_clr_n && !(enc_q && !enc_rst)) |=> $stable(bits_q[i]));
    end

    // R5
    glob_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !glob_clr_n |=> (bits_q == '0));

endmodule

// File: rtl/pixel_hit_cell.sv
module pixel_hit_cell
    import pixel_pkg::*;
#(
    parameter int NUM_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fe_hit_n,
    input  logic [NUM_BITS-1:0] strobe_n,
    input  logic [NUM_BITS-1:0] mem_sel_n,
    input  logic                glob_clr_n,
    input  logic                enc_rst,
    input  logic                pulse_type,
    input  logic                pulse,
    input  logic                cfg_data,
    input  logic                cfg_col,
    input  logic                cfg_row,
    input  logic                cfg_reg,
    output logic                state_out,
    output logic                apulse_req
);

    cfg_t                cfg_q;
    logic                dpulse;
    logic                hit;
    logic [NUM_BITS-1:0] bits_q;

    pixel_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cfg_data (cfg_data),
        .cfg_col  (cfg_col),
        .cfg_row  (cfg_row),
        .cfg_reg  (cfg_reg),
        .cfg_q    (cfg_q)
    );

    pixel_pulse_route u_route (
        .pulse      (pulse),
        .pulse_type (pulse_type),
        .pulse_en   (cfg_q.pulse_en),
        .dpulse     (dpulse),
        .apulse     (apulse_req)
    );

    assign hit = ~fe_hit_n | dpulse;

    pixel_hit_store #(.NUM_BITS(NUM_BITS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .strobe_n   (strobe_n),
        .mem_sel_n  (mem_sel_n),
        .glob_clr_n (glob_clr_n),
        .enc_rst    (enc_rst),
        .bits_q     (bits_q)
    );

    assign state_out = ~cfg_q.mask & (|(bits_q & ~mem_sel_n));

    // R8
    mask_force_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_q.mask |-> !state_out);

    // R10
    apulse_off_chk: assert property (@(posedge clk) disable iff (rst)
        !pulse_type |-> !apulse_req);

endmodule

// File: tb/pixel_hit_cell_tb_top.sv
module pixel_hit_cell_tb_top;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fe_hit_n = 1'b1;
    logic [N-1:0] strobe_n = '1;
    logic [N-1:0] mem_sel_n = '1;
    logic         glob_clr_n = 1'b1;
    logic         enc_rst = 1'b0;
    logic         pulse_type = 1'b0;
    logic         pulse = 1'b0;
    logic         cfg_data = 1'b0;
    logic         cfg_col = 1'b0;
    logic         cfg_row = 1'b0;
    logic         cfg_reg = 1'b0;
    logic         state_out;
    logic         apulse_req;

    int n_run = 0;
    int n_fail = 0;

    // bench model
    logic [N-1:0] m_bits = '0;
    logic         m_mask = 1'b0;
    logic         m_pen = 1'b0;
    logic         m_enc = 1'b0;

    always #4 clk = ~clk;

    pixel_hit_cell #(.NUM_BITS(N)) dut_i (
        .clk(clk), .rst(rst), .fe_hit_n(fe_hit_n), .strobe_n(strobe_n),
        .mem_sel_n(mem_sel_n), .glob_clr_n(glob_clr_n), .enc_rst(enc_rst),
        .pulse_type(pulse_type), .pulse(pulse), .cfg_data(cfg_data),
        .cfg_col(cfg_col), .cfg_row(cfg_row), .cfg_reg(cfg_reg),
        .state_out(state_out), .apulse_req(apulse_req)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_out(input logic [N-1:0] sel_n);
        return !m_mask && ((m_bits & ~sel_n) != '0);
    endfunction

    // one clock: compute model from the driven inputs, then step
    task automatic tick();
        logic [N-1:0] nb;
        logic         h;
        logic         fall;
        logic         nm;
        logic         np;
        h    = !fe_hit_n || (pulse && !pulse_type && m_pen);
        fall = m_enc && !enc_rst;
        nm = m_mask; np = m_pen;
        for (int i = 0; i < N; i++) begin
            if (!glob_clr_n || (fall && !mem_sel_n[i])) nb[i] = 1'b0;
            else if (h && !strobe_n[i])                 nb[i] = 1'b1;
            else                                        nb[i] = m_bits[i];
        end
        if (cfg_col && cfg_row) begin
            if (cfg_reg) nm = cfg_data; else np = cfg_data;
        end
        @(posedge clk);
        if (rst) begin
            m_bits = '0; m_mask = 1'b0; m_pen = 1'b0; m_enc = 1'b0;
        end else begin
            m_bits = nb; m_mask = nm; m_pen = np; m_enc = enc_rst;
        end
        #2;
    endtask

    task automatic sel_check(input string tag, input logic [N-1:0] exp_bits);
        for (int j = 0; j < N; j++) begin
            mem_sel_n = ~(N'(1) << j);
            #1;
            chk(tag, state_out, exp_bits[j]);
        end
        mem_sel_n = '1;
    endtask

    task automatic cfg_write(input logic reg_sel, input logic d);
        cfg_col = 1'b1; cfg_row = 1'b1; cfg_reg = reg_sel; cfg_data = d;
        tick();
        cfg_col = 1'b0; cfg_row = 1'b0; cfg_data = 1'b0;
    endtask

    task automatic clear_all();
        glob_clr_n = 1'b0; tick(); glob_clr_n = 1'b1;
    endtask

    task automatic capture(input logic [N-1:0] which);
        fe_hit_n = 1'b0; strobe_n = ~which; tick();
        fe_hit_n = 1'b1; strobe_n = '1;
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R1 reset state
        #2;
        tick(); tick();
        pulse = 1'b1; pulse_type = 1'b1;
        #1 chk("R1 apulse during reset", apulse_req, 1'b0);
        rst = 1'b0;
        tick();
        chk("R1 apulse after reset", apulse_req, 1'b0);
        sel_check("R1 state after reset", 3'b000);

        // R9 partial select ignored, full select loads pulse enable
        cfg_col = 1'b1; cfg_row = 1'b0; cfg_reg = 1'b0; cfg_data = 1'b1; tick();
        cfg_col = 1'b0; cfg_row = 1'b1; tick();
        cfg_row = 1'b0;
        chk("R9 partial select no load", apulse_req, 1'b0);
        cfg_write(1'b0, 1'b1);
        chk("R9 R10 pulse enable loaded", apulse_req, 1'b1);
        pulse = 1'b0; #1;
        chk("R10 no pulse", apulse_req, 1'b0);
        pulse_type = 1'b0; pulse = 1'b1; #1;
        chk("R10 digital route no request", apulse_req, 1'b0);
        pulse = 1'b0;

        // R2 R4 each bit alone
        for (int i = 0; i < N; i++) begin
            clear_all();
            capture(N'(1) << i);
            sel_check("R2 R4 single capture", N'(1) << i);
        end
        mem_sel_n = '0; #1;
        chk("R4 no-select OR of all", state_out, 1'b1);
        mem_sel_n = '1; #1;
        chk("R4 nothing selected", state_out, 1'b0);

        // R3
        clear_all();
        fe_hit_n = 1'b0; tick(); fe_hit_n = 1'b1;
        sel_check("R3 hit without strobe", 3'b000);
        strobe_n = '0; tick(); strobe_n = '1;
        sel_check("R3 strobe without hit", 3'b000);

        // R6 falling edge only
        capture(3'b111);
        mem_sel_n = 3'b101;
        enc_rst = 1'b1; tick();
        #1 chk("R6 rising edge no clear", state_out, 1'b1);
        tick();
        chk("R6 held high no clear", state_out, 1'b1);
        enc_rst = 1'b0; tick();
        chk("R6 falling edge clears selected", state_out, 1'b0);
        tick();
        sel_check("R6 others kept", 3'b101);

        // R7 collision
        mem_sel_n = 3'b110;
        enc_rst = 1'b1; tick();
        enc_rst = 1'b0; fe_hit_n = 1'b0; strobe_n = 3'b110; tick();
        fe_hit_n = 1'b1; strobe_n = '1;
        sel_check("R7 encoder clear beats set", 3'b100);
        glob_clr_n = 1'b0; fe_hit_n = 1'b0; strobe_n = '0; tick();
        glob_clr_n = 1'b1; fe_hit_n = 1'b1; strobe_n = '1;
        sel_check("R7 R5 global clear beats set", 3'b000);

        // R5
        capture(3'b011);
        clear_all();
        sel_check("R5 global clear", 3'b000);

        // R8 mask
        capture(3'b100);
        cfg_write(1'b1, 1'b1);
        sel_check("R8 masked", 3'b000);
        cfg_col = 1'b1; cfg_reg = 1'b1; cfg_data = 1'b0; tick(); cfg_col = 1'b0;
        sel_check("R8 R9 mask kept on partial select", 3'b000);
        cfg_write(1'b1, 1'b0);
        sel_check("R8 bits kept under mask", 3'b100);

        // R11 and R10 digital vs analogue injection
        clear_all();
        pulse = 1'b1; pulse_type = 1'b0; strobe_n = 3'b110; tick();
        pulse_type = 1'b1; strobe_n = 3'b101; tick();
        pulse = 1'b0; strobe_n = '1;
        sel_check("R11 R10 digital sets, analogue not", 3'b001);
        cfg_write(1'b0, 1'b0);
        pulse = 1'b1; pulse_type = 1'b0; strobe_n = 3'b011; tick();
        pulse = 1'b0; strobe_n = '1;
        sel_check("R11 disabled pulse ignored", 3'b001);

        // random sweep against model
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] r;
            r = $urandom;
            fe_hit_n   = r[0] | r[1];
            strobe_n   = r[4:2];
            mem_sel_n  = ~(N'(1) << (r[6:5] % 3)) | {N{r[7] & r[8]}};
            glob_clr_n = !(r[9] & r[10] & r[11]);
            enc_rst    = r[12];
            pulse_type = r[13];
            pulse      = r[14];
            cfg_col    = r[15];
            cfg_row    = r[16] & r[17];
            cfg_reg    = r[18];
            cfg_data   = r[19] & (r[20] | !r[18]);
            #1;
            chk("R10 random apulse", apulse_req, pulse && pulse_type && m_pen);
            tick();
            chk("R4 random state_out", state_out, m_out(mem_sel_n));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule